// File: doc/BRIEF.md
# I2C EEPROM Transaction Sequencer

This block turns host commands into the ordered list of byte-level operations that a serial EEPROM with a 128 KB array expects. It sits between a host and a byte-level I2C master engine. It does not drive SCL or SDA. It asks the engine for START, STOP, send-byte and receive-byte operations, one at a time. After each one it waits for completion and, for sends, for the slave's acknowledge.

A host command is either a single-byte write or a random read of 1 to 256 bytes at a 17-bit byte address. Address bit 16 does not travel as a word-address byte. It selects one of the two 64 KB halves through bit 1 of the device byte. A read first sets the internal pointer with a write-direction header. It then turns the bus around with a repeated START. When the slave does not acknowledge, for example while it is busy with an internal write cycle, the sequencer can restart the transaction from START automatically, up to a programmable retry limit. Otherwise the NACK ends the command with an error.

Top module: `eeseq_top`

## Requirements
- R1: Every transaction opens with a START request (engine op code 0) followed by a send (op code 2) of the device byte. Each request to the engine is a single-cycle strobe, and no new request is made until the engine reports done or a fault. STOP is op code 1 and receive is op code 3.
- R2: The device byte is the base value 0xA0 with its two low bits cleared. Bit 1 then carries address bit 16 (0xA2 for the upper half), and bit 0 carries the direction (1 = read).
- R3: After the write-direction device byte is acknowledged, address bits 15:8 are sent, and then address bits 7:0.
- R4: A write sends its data byte after the low address byte, then requests STOP, and busy returns low once the STOP completes.
- R5: A read, after the low address byte is acknowledged, requests a repeated START (op code 0) and sends the device byte with bit 0 set.
- R6: A read receives `cmdLenM1`+1 bytes. It presents each byte on `rdData` with a one-cycle `rdValid` pulse. It asks for ACK (`engRxAck`=1) on every byte but the last, asks for NACK on the last, and then requests STOP.
- R7: With `pollEn` high, a send that the slave NACKs makes the sequencer restart the whole transaction from START, and the command then completes normally without error.
- R8: With `pollEn` low, a NACKed send aborts the command: `engReset` pulses for one cycle, no STOP is requested, busy falls and `err` rises.
- R9: A read never runs past the end of a 64 KB half. When the requested length would cross address 0xFFFF within a half, only the bytes up to and including 0xFFFF are read, and the last of those is NACKed.
- R10: With `pollEn` high, at most `MAX_RETRY` restarts are made per command. A further NACK aborts the command as in R8.
- R11: A command presented while busy is high is ignored. No operation is requested for it, before or after the current command ends.
- R12: An `engFault` report aborts the command as in R8, whatever the value of `pollEn`.
- R13: After reset, busy, err and rdValid are low. `err` stays high until the next accepted command, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, taken only while busy is low |
| cmdRead | input | 1 | 1 = random read, 0 = byte write |
| cmdAddr | input | 17 | Byte address; bit 16 selects the half |
| cmdWrData | input | 8 | Byte to write |
| cmdLenM1 | input | 8 | Read length minus one |
| pollEn | input | 1 | Restart on NACK instead of aborting |
| busy | output | 1 | Command in progress |
| err | output | 1 | Last command aborted |
| rdData | output | 8 | Received byte |
| rdValid | output | 1 | rdData strobe |
| engReq | output | 1 | Operation request strobe to the byte engine |
| engOp | output | 2 | 0 START, 1 STOP, 2 send, 3 receive |
| engTxByte | output | 8 | Byte to send |
| engRxAck | output | 1 | Acknowledge to return after a receive (1 = ACK) |
| engReset | output | 1 | Abort pulse that resets the byte engine |
| engDone | input | 1 | Operation complete |
| engAck | input | 1 | Slave acknowledged the sent byte |
| engFault | input | 1 | Engine reported an unexpected status |
| engRxByte | input | 8 | Byte received, valid with engDone |

## Verification
The bench builds the sequencer with `MAX_RETRY` = 3 and keeps the default base address 0xA0. With that small limit the retry-exhaustion abort happens within a handful of restarts, so the case where the limit runs out and the case where a later attempt succeeds can both be checked in short directed runs. The bench's engine model answers each request after a fixed delay and can NACK a chosen number of device bytes or report a fault. This drives the restart, abort and fault paths, the read clipped at the 64 KB boundary, and a command presented while busy.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_SEND  = 2'd2,
    OP_RECV  = 2'd3
  } engOp_e;

  typedef enum logic [2:0] {
    SEL_DEVW,
    SEL_DEVR,
    SEL_AH,
    SEL_AL,
    SEL_DATA
  } txSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   clrRx;
    logic   incRx;
    logic   incRetry;
    txSel_e sel;
  } strb_t;
endpackage

// File: rtl/eeseq_dp.sv
module eeseq_dp
  import eeseq_pkg::*;
#(
  parameter logic [7:0] DEV_BASE  = 8'hA0,
  parameter int         MAX_RETRY = 1023,
  parameter int         LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic             cmdRead,
  input  logic [16:0]      cmdAddr,
  input  logic [7:0]       cmdWrData,
  input  logic [LEN_W-1:0] cmdLenM1,
  input  logic [7:0]       engRxByte,
  output logic [7:0]       txByte,
  output logic             isRead,
  output logic             isLast,
  output logic             retryDone,
  output logic [7:0]       rdData,
  output logic             rdValid
);
  localparam int RETRY_W = $clog2(MAX_RETRY + 1);
  localparam int PAD_W   = 16 - LEN_W;

  logic [16:0]        addrQ;
  logic [7:0]         dataQ;
  logic               readQ;
  logic [LEN_W-1:0]   lastIdxQ;
  logic [LEN_W-1:0]   rxCnt;
  logic [RETRY_W-1:0] retryQ;
  logic [15:0]        room;
  logic [LEN_W-1:0]   lastIdxD;
  logic [7:0]         devHead;

  // bytes left in the current 64 KB half, minus one
  assign room = 16'hFFFF - cmdAddr[15:0];
  always_comb begin
    if (room < {{PAD_W{1'b0}}, cmdLenM1}) lastIdxD = room[LEN_W-1:0];
    else                                   lastIdxD = cmdLenM1;
  end

  assign devHead = (DEV_BASE & 8'hFC) | {6'b0, addrQ[16], 1'b0};

  always_comb begin
    case (strb.sel)
      SEL_DEVR: txByte = devHead | 8'h01;
      SEL_AH:   txByte = addrQ[15:8];
      SEL_AL:   txByte = addrQ[7:0];
      SEL_DATA: txByte = dataQ;
      default:  txByte = devHead;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      readQ    <= 1'b0;
      lastIdxQ <= '0;
    end else if (strb.load) begin
      addrQ    <= cmdAddr;
      dataQ    <= cmdWrData;
      readQ    <= cmdRead;
      lastIdxQ <= cmdRead ? lastIdxD : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxCnt <= '0;
    else if (strb.clrRx)    rxCnt <= '0;
    else if (strb.incRx)    rxCnt <= rxCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              retryQ <= '0;
    else if (strb.load)     retryQ <= '0;
    else if (strb.incRetry) retryQ <= retryQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.incRx;
      if (strb.incRx) rdData <= engRxByte;
    end
  end

  assign isRead    = readQ;
  assign isLast    = (rxCnt == lastIdxQ);
  assign retryDone = (retryQ == RETRY_W'(MAX_RETRY));
endmodule

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
  import eeseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       pollEn,
  input  logic       engDone,
  input  logic       engAck,
  input  logic       engFault,
  input  logic       isRead,
  input  logic       isLast,
  input  logic       retryDone,
  output strb_t      strb,
  output logic       engReq,
  output logic [1:0] engOp,
  output logic       engRxAck,
  output logic       engReset,
  output logic       busy,
  output logic       err
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_ABORT} state_e;
  typedef enum logic [3:0] {
    P_START, P_DEV, P_AH, P_AL, P_DATA, P_RSTART, P_DEVR, P_RECV, P_STOP
  } phase_e;

  state_e state, nState;
  phase_e phase, nPhase;
  engOp_e opNow;

  always_comb begin
    case (phase)
      P_START, P_RSTART: opNow = OP_START;
      P_STOP:            opNow = OP_STOP;
      P_RECV:            opNow = OP_RECV;
      default:           opNow = OP_SEND;
    endcase
  end

  always_comb begin
    nState        = state;
    nPhase        = phase;
    strb          = '0;
    case (phase)
      P_DEVR:  strb.sel = SEL_DEVR;
      P_AH:    strb.sel = SEL_AH;
      P_AL:    strb.sel = SEL_AL;
      P_DATA:  strb.sel = SEL_DATA;
      default: strb.sel = SEL_DEVW;
    endcase
    case (state)
      S_IDLE: if (cmdValid) begin
        strb.load = 1'b1;
        nState    = S_ISSUE;
        nPhase    = P_START;
      end
      S_ISSUE: begin
        nState = S_WAIT;
        if (opNow == OP_START) strb.clrRx = 1'b1;
      end
      S_WAIT: begin
        if (engFault) nState = S_ABORT;
        else if (engDone) begin
          if (opNow == OP_SEND && !engAck) begin
            if (pollEn && !retryDone) begin
              strb.incRetry = 1'b1;
              nPhase        = P_START;
              nState        = S_ISSUE;
            end else begin
              nState = S_ABORT;
            end
          end else begin
            nState = S_ISSUE;
            case (phase)
              P_START:  nPhase = P_DEV;
              P_DEV:    nPhase = P_AH;
              P_AH:     nPhase = P_AL;
              P_AL:     nPhase = isRead ? P_RSTART : P_DATA;
              P_DATA:   nPhase = P_STOP;
              P_RSTART: nPhase = P_DEVR;
              P_DEVR:   nPhase = P_RECV;
              P_RECV: begin
                strb.incRx = 1'b1;
                nPhase     = isLast ? P_STOP : P_RECV;
              end
              default:  nState = S_IDLE;
            endcase
          end
        end
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= P_START;
      err   <= 1'b0;
    end else begin
      state <= nState;
      phase <= nPhase;
      if (strb.load)            err <= 1'b0;
      else if (state == S_ABORT) err <= 1'b1;
    end
  end

  assign engReq   = (state == S_ISSUE);
  assign engOp    = opNow;
  assign engRxAck = !isLast;
  assign engReset = (state == S_ABORT);
  assign busy     = (state != S_IDLE);
endmodule

// File: rtl/eeseq_top.sv
module eeseq_top
  import eeseq_pkg::*;
#(
  parameter logic [7:0] DEV_BASE  = 8'hA0,
  parameter int         MAX_RETRY = 1023
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdRead,
  input  logic [16:0] cmdAddr,
  input  logic [7:0]  cmdWrData,
  input  logic [7:0]  cmdLenM1,
  input  logic        pollEn,
  output logic        busy,
  output logic        err,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        engReq,
  output logic [1:0]  engOp,
  output logic [7:0]  engTxByte,
  output logic        engRxAck,
  output logic        engReset,
  input  logic        engDone,
  input  logic        engAck,
  input  logic        engFault,
  input  logic [7:0]  engRxByte
);
  strb_t strb;
  logic  isRead, isLast, retryDone;

  eeseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .pollEn(pollEn),
    .engDone(engDone), .engAck(engAck), .engFault(engFault),
    .isRead(isRead), .isLast(isLast), .retryDone(retryDone),
    .strb(strb), .engReq(engReq), .engOp(engOp), .engRxAck(engRxAck),
    .engReset(engReset), .busy(busy), .err(err)
  );

  eeseq_dp #(.DEV_BASE(DEV_BASE), .MAX_RETRY(MAX_RETRY), .LEN_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdRead(cmdRead),
    .cmdAddr(cmdAddr), .cmdWrData(cmdWrData), .cmdLenM1(cmdLenM1),
    .engRxByte(engRxByte), .txByte(engTxByte), .isRead(isRead),
    .isLast(isLast), .retryDone(retryDone), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/eeseq_chk.sv
module eeseq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       err,
  input logic       rdValid,
  input logic       engReq,
  input logic [1:0] engOp,
  input logic       engReset
);
  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (engReq && engOp == 2'd0)); // R1
  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    engReq |=> !engReq); // R1
  AST_RDVALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy); // R6
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rstN)
    engReset |=> (err && !busy)); // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !engReq); // R11
endmodule

bind eeseq_top eeseq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .err(err), .rdValid(rdValid),
  .engReq(engReq), .engOp(engOp), .engReset(engReset)
);

// File: tb/sim_eeseq_top.sv
module sim_eeseq_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdRead = 1'b0, pollEn = 1'b0;
  logic [16:0] cmdAddr = '0;
  logic [7:0] cmdWrData = '0, cmdLenM1 = '0;
  logic busy, err, rdValid, engReq, engRxAck, engReset;
  logic [7:0] rdData, engTxByte;
  logic [1:0] engOp;
  logic engDone = 1'b0, engAck = 1'b0, engFault = 1'b0;
  logic [7:0] engRxByte = '0;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  eeseq_top #(.DEV_BASE(8'hA0), .MAX_RETRY(3)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdAddr(cmdAddr), .cmdWrData(cmdWrData), .cmdLenM1(cmdLenM1),
    .pollEn(pollEn), .busy(busy), .err(err), .rdData(rdData),
    .rdValid(rdValid), .engReq(engReq), .engOp(engOp),
    .engTxByte(engTxByte), .engRxAck(engRxAck), .engReset(engReset),
    .engDone(engDone), .engAck(engAck), .engFault(engFault),
    .engRxByte(engRxByte)
  );

  // byte-engine model with an operation log
  logic [1:0] logOp [0:63];
  logic [7:0] logByte [0:63];
  logic       logAck [0:63];
  int logN = 0, dly = 0, nackLeft = 0, rxSeen = 0, resetSeen = 0;
  logic faultArm = 1'b0, afterStart = 1'b0;
  logic [1:0] pendOp = '0;

  always @(posedge clk) begin
    engDone  <= 1'b0;
    engFault <= 1'b0;
    if (engReset) begin
      resetSeen <= resetSeen + 1;
      dly <= 0;
    end else if (engReq) begin
      if (logN < 64) begin
        logOp[logN]   <= engOp;
        logByte[logN] <= engTxByte;
        logAck[logN]  <= engRxAck;
      end
      logN   <= logN + 1;
      pendOp <= engOp;
      dly    <= 2;
    end else if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        if (faultArm) begin
          engFault <= 1'b1;
          faultArm <= 1'b0;
        end else begin
          engDone <= 1'b1;
          case (pendOp)
            2'd0: begin afterStart <= 1'b1; rxSeen <= 0; end
            2'd2: begin
              afterStart <= 1'b0;
              if (afterStart && nackLeft > 0) begin
                engAck <= 1'b0;
                nackLeft <= nackLeft - 1;
              end else engAck <= 1'b1;
            end
            2'd3: begin
              engRxByte <= 8'h30 + 8'(rxSeen);
              rxSeen <= rxSeen + 1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  logic [7:0] rdBuf [0:15];
  int rdN = 0;
  always @(negedge clk) if (rdValid) begin
    if (rdN < 16) rdBuf[rdN] <= rdData;
    rdN <= rdN + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic entry(input int i, input int op, input int b, input string tag);
    check(logOp[i] == 2'(op), tag, int'(logOp[i]), op);
    if (op == 2) check(logByte[i] == 8'(b), tag, int'(logByte[i]), b);
  endtask

  task automatic clearLog();
    @(negedge clk);
    logN = 0; rdN = 0; resetSeen = 0;
  endtask

  task automatic issue(input logic rd, input logic [16:0] a, input logic [7:0] d, input logic [7:0] lm1);
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = rd; cmdAddr = a; cmdWrData = d; cmdLenM1 = lm1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, tag, int'(busy), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    check(!busy && !err && !rdValid, "R13 reset state", {busy, err, rdValid}, 0);
  endtask

  task automatic tWrite();
    clearLog();
    issue(1'b0, 17'h01234, 8'h5A, 8'h00);
    waitIdle("R4 write done");
    check(logN == 6, "R4 write op count", logN, 6);
    entry(0, 0, 0, "R1 start first");
    entry(1, 2, 8'hA0, "R2 device byte low half");
    entry(2, 2, 8'h12, "R3 high address");
    entry(3, 2, 8'h34, "R3 low address");
    entry(4, 2, 8'h5A, "R4 data byte");
    entry(5, 1, 0, "R4 stop");
    check(!err, "R4 no error", int'(err), 0);
  endtask

  task automatic tWriteHigh();
    clearLog();
    issue(1'b0, 17'h1ABCD, 8'hC3, 8'h00);
    waitIdle("R2 write upper done");
    entry(1, 2, 8'hA2, "R2 device byte upper half");
    entry(2, 2, 8'hAB, "R3 high address upper");
    entry(3, 2, 8'hCD, "R3 low address upper");
  endtask

  task automatic tRead();
    clearLog();
    issue(1'b1, 17'h00010, 8'h00, 8'd2);
    waitIdle("R6 read done");
    check(logN == 10, "R5 read op count", logN, 10);
    entry(1, 2, 8'hA0, "R5 write-direction header");
    entry(2, 2, 8'h00, "R3 read high address");
    entry(3, 2, 8'h10, "R3 read low address");
    entry(4, 0, 0, "R5 repeated start");
    entry(5, 2, 8'hA1, "R5 read device byte");
    entry(6, 3, 0, "R6 receive 0");
    check(logAck[6] && logAck[7] && !logAck[8], "R6 ack pattern",
          {logAck[6], logAck[7], logAck[8]}, 3'b110);
    entry(9, 1, 0, "R6 stop after read");
    check(rdN == 3, "R6 byte count", rdN, 3);
    check(rdBuf[0] == 8'h30 && rdBuf[2] == 8'h32, "R6 read data",
          {rdBuf[0], rdBuf[2]}, 16'h3032);
  endtask

  task automatic tBoundary();
    clearLog();
    issue(1'b1, 17'h1FFFE, 8'h00, 8'd4);
    waitIdle("R9 clipped read done");
    check(logN == 9, "R9 op count", logN, 9);
    entry(5, 2, 8'hA3, "R9 upper read device byte");
    check(rdN == 2, "R9 clipped length", rdN, 2);
    check(logAck[6] && !logAck[7], "R9 last byte nack",
          {logAck[6], logAck[7]}, 2'b10);
    entry(8, 1, 0, "R9 stop");
  endtask

  task automatic tPoll();
    clearLog();
    pollEn = 1'b1; nackLeft = 2;
    issue(1'b0, 17'h00020, 8'h11, 8'h00);
    waitIdle("R7 poll done");
    check(logN == 10, "R7 op count", logN, 10);
    entry(2, 0, 0, "R7 restart 1");
    entry(4, 0, 0, "R7 restart 2");
    entry(5, 2, 8'hA0, "R7 device after restart");
    entry(8, 2, 8'h11, "R7 data");
    check(!err, "R7 no error", int'(err), 0);
  endtask

  task automatic tNoPoll();
    clearLog();
    pollEn = 1'b0; nackLeft = 1;
    issue(1'b0, 17'h00030, 8'h22, 8'h00);
    waitIdle("R8 abort idle");
    check(logN == 2, "R8 no stop after nack", logN, 2);
    check(err, "R8 err raised", int'(err), 1);
    check(resetSeen == 1, "R8 engine reset pulse", resetSeen, 1);
    nackLeft = 0;
  endtask

  task automatic tExhaust();
    clearLog();
    pollEn = 1'b1; nackLeft = 10;
    issue(1'b0, 17'h00040, 8'h33, 8'h00);
    waitIdle("R10 exhaust idle");
    check(logN == 8, "R10 attempts", logN, 8);
    check(err, "R10 err raised", int'(err), 1);
    nackLeft = 0;
  endtask

  task automatic tFault();
    clearLog();
    pollEn = 1'b1; faultArm = 1'b1;
    issue(1'b0, 17'h00050, 8'h44, 8'h00);
    waitIdle("R12 fault idle");
    check(logN == 1, "R12 abort on fault", logN, 1);
    check(err && resetSeen == 1, "R12 err and reset", {err, 1'b0}, 2);
  endtask

  task automatic tErrClear();
    clearLog();
    issue(1'b0, 17'h00060, 8'h55, 8'h00);
    check(busy && !err, "R13 err cleared on accept", {busy, err}, 2);
    waitIdle("R13 write after error");
    check(!err && logN == 6, "R13 clean completion", logN, 6);
  endtask

  task automatic tBusyIgnore();
    clearLog();
    issue(1'b1, 17'h00100, 8'h00, 8'd1);
    repeat (3) @(negedge clk);
    cmdValid = 1'b1; cmdRead = 1'b0; cmdAddr = 17'h05555; cmdWrData = 8'h99;
    @(negedge clk);
    cmdValid = 1'b0;
    waitIdle("R11 read done");
    repeat (10) @(negedge clk);
    check(!busy, "R11 no second command", int'(busy), 0);
    check(logN == 9, "R11 op count", logN, 9);
    entry(2, 2, 8'h01, "R11 address kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrite();
    tWriteHigh();
    tRead();
    tBoundary();
    tPoll();
    tNoPoll();
    tExhaust();
    tFault();
    tErrClear();
    tBusyIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule